// File: doc/BRIEF.md
# Parallel Port Controller with Handshake

This block connects a processor bus to three 8-bit parallel ports, called A, B and C, through a small register interface. The bus side uses a 2-bit register address, an active-low chip select, active-low read and write strobes, an 8-bit write bus and an 8-bit read bus. A single control register decides what each port does. A control write with the top bit set is a configuration word that picks the direction and operating mode of each group. A control write with the top bit clear changes one bit of the port C output latch and leaves the configuration as it was. Every pad is modelled as three vectors (pin value in, value out and output enable), so the tri-state buffer sits outside the block.

The ports are split into two groups. Group A owns port A and the upper half of port C. Group B owns port B and the lower half of port C. Each group can run as plain I/O with no handshake, or as a strobed channel. In a strobed channel, some port C pins are given over to a strobe or acknowledge input, a buffer-status output and an interrupt output. Each strobed channel is run by a four-state machine, `hs_state_e`:
- `HS_IDLE`: input latch empty, or output buffer empty.
- `HS_LATCH`: the strobe is low and data has been captured.
- `HS_FULL`: the strobe has been released and the data waits for the CPU.
- `HS_WAIT_ACK`: the CPU has written, and the block waits for the peripheral's acknowledge.

The transitions are:
- `HS_IDLE` to `HS_LATCH` on a strobe falling edge while in input direction.
- `HS_LATCH` to `HS_FULL` on the strobe rising edge.
- `HS_FULL` to `HS_IDLE` when a CPU read of the port completes.
- `HS_IDLE` to `HS_WAIT_ACK` on a CPU write while in output direction.
- `HS_WAIT_ACK` to `HS_IDLE` while acknowledge is low.
- Any state to `HS_IDLE` on a configuration write, or when the group is not in strobed mode.

All bus strobes and handshake pins are sampled on the rising clock edge, and edges are found by comparing each pin with its value one clock earlier.

Top module: `pport_ctl`

## Requirements
- R1: A high `rst` sets the control register to 9Bh: every port is an input and every output enable is 0. Reading address 11 then returns 9Bh.
- R2: Address 00 selects port A, 01 selects port B, 10 selects port C and 11 selects the control register. Reading address 11 returns the last configuration word written.
- R3: A configuration word (bit 7 = 1) sets four directions, where a 1 means input: bit 4 for port A, bit 3 for C[7:4], bit 1 for port B and bit 0 for C[3:0]. Writing a configuration word clears all three output latches.
- R4: A control write with bit 7 = 0 loads bit 0 into port C latch bit number din[3:1] and leaves the control register unchanged. For example, 0Bh sets C5 and 0Eh clears C7.
- R5: In plain mode, an output port drives its latch onto its pins, and a read of an input port returns its pins directly. A read of port C mixes the two, nibble by nibble.
- R6: Group A strobed mode is selected by bits 6..5 = 01, and group B strobed mode by bit 2 = 1. For an input channel the pins are: port A uses STB = C4, IBF = C5 and INTR = C3; port B uses STB = C2, IBF = C1 and INTR = C0. A low STB captures the port pins. IBF goes high in the cycle after STB is first seen low, and a read of the port returns the captured byte, not the live pins.
- R7: INTR of an input channel goes high on the rising edge of STB only when its enable bit is 1, and goes low on the falling edge of a read of that port. The enable bit is port C latch bit 4 for port A input, bit 6 for port A output and bit 2 for port B, and it is written by a single-bit command.
- R8: IBF goes low once a read of the port ends (read strobe high again). While IBF is high, further strobes are ignored and the captured byte is kept.
- R9: For an output channel the pins are: port A uses OBF = C7, ACK = C6 and INTR = C3; port B uses OBF = C1, ACK = C2 and INTR = C0. OBF is active low. A CPU write to the port drives OBF low and clears INTR. A low ACK returns OBF high and sets INTR if the channel's enable bit is 1.
- R10: In strobed mode, a read of port C returns the status outputs at their pin positions and the enable bit at the strobe or acknowledge position. A data write to port C does not change the latch bits at handshake positions.
- R11: A group A mode field of 10 or 11 is treated as plain mode: no port C pin is taken for handshake.
- R12: In strobed mode, strobe and acknowledge pins are inputs and status pins are outputs, whatever the port C nibble direction bits say. The remaining port C pins follow their nibble's direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every register |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| din | input | 8 | Write data from the CPU |
| dout | output | 8 | Read data for the selected register |
| dout_en | output | 1 | High while a read of this block is in progress |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A drive values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B drive values |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin values, including strobe and acknowledge |
| pc_out | output | 8 | Port C drive values, including status pins |
| pc_oe | output | 8 | Port C output enables |

## Verification
The configuration decoder is tried with several words:
- All-output and mixed-direction words tell the four direction bits apart and show that the output latches are cleared.
- An unsupported group A mode shows that no port C pin is taken for handshake.
- Input and output strobed words show which pins each channel claims.

In the input channel, a strobe with the enable bit set is contrasted with one where it is clear, and a second strobe while the buffer is full must leave the captured byte in place. The bench also changes the port A pins while the strobe is still low, which shows that data is captured at the strobe edge. In the output channel, a write and acknowledge pair with interrupts enabled shows the OBF and INTR sequence. A second write shows that a write clears the interrupt. A final port C read checks that every status and enable bit appears at its own pin position.

// File: rtl/pport_pkg.sv
`timescale 1ns/1ps
package pport_pkg;
    localparam int unsigned PORT_W   = 8;
    localparam int unsigned ADDR_W   = 2;
    localparam int unsigned SEL_W    = $clog2(PORT_W);
    localparam int unsigned NIB_W    = PORT_W / 2;
    localparam int unsigned MODE_BIT = PORT_W - 1;
    localparam logic [PORT_W-1:0] CTL_RESET = 8'h9B;

    // handshake pin positions inside port C
    localparam int unsigned PIN_B_INTR = 0;
    localparam int unsigned PIN_B_STAT = 1;
    localparam int unsigned PIN_B_STB  = 2;
    localparam int unsigned PIN_A_INTR = 3;
    localparam int unsigned PIN_A_STB  = 4;
    localparam int unsigned PIN_A_IBF  = 5;
    localparam int unsigned PIN_A_ACK  = 6;
    localparam int unsigned PIN_A_OBF  = 7;

    typedef enum logic [ADDR_W-1:0] {
        SEL_A   = 2'b00,
        SEL_B   = 2'b01,
        SEL_C   = 2'b10,
        SEL_CTL = 2'b11
    } sel_e;

    typedef struct packed {
        logic a_hs;
        logic a_in;
        logic cu_in;
        logic b_hs;
        logic b_in;
        logic cl_in;
    } cfg_t;

    typedef enum logic [1:0] {
        HS_IDLE     = 2'd0,
        HS_LATCH    = 2'd1,
        HS_FULL     = 2'd2,
        HS_WAIT_ACK = 2'd3
    } hs_state_e;
endpackage

// File: rtl/pport_regs.sv
`timescale 1ns/1ps
module pport_regs
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctl,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic              wr_c,
    input  logic [PORT_W-1:0] wdata,
    input  logic [PORT_W-1:0] hs_mask,
    output logic [PORT_W-1:0] ctl_word,
    output logic [PORT_W-1:0] pa_lat,
    output logic [PORT_W-1:0] pb_lat,
    output logic [PORT_W-1:0] pc_lat,
    output logic              cfg_clr,
    output cfg_t              cfg
);
    logic [SEL_W-1:0] bsr_sel;

    assign bsr_sel = wdata[SEL_W:1];
    assign cfg_clr = wr_ctl && wdata[MODE_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_word <= CTL_RESET;
            pa_lat   <= '0;
            pb_lat   <= '0;
            pc_lat   <= '0;
        end else if (wr_ctl) begin
            if (wdata[MODE_BIT]) begin
                ctl_word <= wdata;
                pa_lat   <= '0;
                pb_lat   <= '0;
                pc_lat   <= '0;
            end else begin
                pc_lat[bsr_sel] <= wdata[0];
            end
        end else begin
            if (wr_a) pa_lat <= wdata;
            if (wr_b) pb_lat <= wdata;
            if (wr_c) pc_lat <= (pc_lat & hs_mask) | (wdata & ~hs_mask);
        end
    end

    always_comb begin
        cfg.a_hs  = (ctl_word[6:5] == 2'b01);
        cfg.a_in  = ctl_word[4];
        cfg.cu_in = ctl_word[3];
        cfg.b_hs  = ctl_word[2];
        cfg.b_in  = ctl_word[1];
        cfg.cl_in = ctl_word[0];
    end

    // R3: configuration word is kept and latches are emptied
    assert_mode_word_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && wdata[MODE_BIT]) |=>
            (ctl_word == $past(wdata)) && (pa_lat == '0) && (pb_lat == '0) && (pc_lat == '0));

    // R4: single-bit command touches one latch bit and not the control register
    assert_bit_cmd_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && !wdata[MODE_BIT]) |=>
            (pc_lat[$past(bsr_sel)] == $past(wdata[0])) && $stable(ctl_word));
endmodule

// File: rtl/pport_hs_chan.sv
`timescale 1ns/1ps
module pport_hs_chan
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic              is_in,
    input  logic              stb_n,
    input  logic              inte,
    input  logic              cpu_wr,
    input  logic              cpu_rd_fall,
    input  logic              cpu_rd_done,
    input  logic [PORT_W-1:0] pdata,
    output logic              ibf,
    output logic              obf_n,
    output logic              intr,
    output logic [PORT_W-1:0] held
);
    hs_state_e state, state_nx;
    logic      stb_q;
    logic      stb_fall;
    logic      stb_rise;

    assign stb_fall = stb_q && !stb_n;
    assign stb_rise = !stb_q && stb_n;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= HS_IDLE;
        else     state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (clr || !en) begin
            state_nx = HS_IDLE;
        end else begin
            unique case (state)
                HS_IDLE: begin
                    if (is_in && stb_fall)      state_nx = HS_LATCH;
                    else if (!is_in && cpu_wr)  state_nx = HS_WAIT_ACK;
                end
                HS_LATCH: begin
                    if (!is_in)                 state_nx = HS_IDLE;
                    else if (stb_rise)          state_nx = HS_FULL;
                end
                HS_FULL: begin
                    if (!is_in || cpu_rd_done)  state_nx = HS_IDLE;
                end
                HS_WAIT_ACK: begin
                    if (is_in || !stb_n)        state_nx = HS_IDLE;
                end
                default:                        state_nx = HS_IDLE;
            endcase
        end
    end

    // status outputs
    always_comb begin
        ibf   = 1'b0;
        obf_n = 1'b1;
        unique case (state)
            HS_IDLE:     ;
            HS_LATCH:    ibf   = 1'b1;
            HS_FULL:     ibf   = 1'b1;
            HS_WAIT_ACK: obf_n = 1'b0;
            default:     ;
        endcase
    end

    // edge history, captured data and interrupt flag
    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q <= 1'b1;
            held  <= '0;
            intr  <= 1'b0;
        end else begin
            stb_q <= stb_n;
            if (en && is_in && !clr && state == HS_IDLE && stb_fall)
                held <= pdata;
            if (clr || !en || !inte) begin
                intr <= 1'b0;
            end else if (is_in) begin
                if (state == HS_LATCH && stb_rise) intr <= 1'b1;
                else if (cpu_rd_fall)              intr <= 1'b0;
            end else begin
                if (state == HS_WAIT_ACK && !stb_n) intr <= 1'b1;
                else if (cpu_wr)                    intr <= 1'b0;
            end
        end
    end

    assert_ibf_set_R6: assert property (@(posedge clk) disable iff (rst)
        (en && is_in && !clr && state == HS_IDLE && stb_fall) |=> ibf);

    assert_ibf_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && ibf && !cpu_rd_done) |=> ibf);

    assert_intr_gate_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(intr) |-> $past(inte && en));

    assert_ack_release_R9: assert property (@(posedge clk) disable iff (rst)
        (en && !is_in && !clr && state == HS_WAIT_ACK && !stb_n) |=>
            (obf_n && (intr == $past(inte))));
endmodule

// File: rtl/pport_ctl.sv
`timescale 1ns/1ps
module pport_ctl
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] din,
    output logic [PORT_W-1:0] dout,
    output logic              dout_en,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic [PORT_W-1:0] pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    output logic [PORT_W-1:0] pb_oe,
    input  logic [PORT_W-1:0] pc_in,
    output logic [PORT_W-1:0] pc_out,
    output logic [PORT_W-1:0] pc_oe
);
    sel_e              sel, rd_sel;
    logic              wr_q, rd_q, rd_busy;
    logic              wr_fire, rd_fall, rd_done;
    logic [PORT_W-1:0] ctl_word, pa_lat, pb_lat, pc_lat;
    logic              cfg_clr;
    cfg_t              cfg;
    logic [PORT_W-1:0] hs_mask, stat_mask, stb_mask, pc_stat, nib_out;
    logic [PORT_W-1:0] held_a, held_b, pa_rd, pb_rd, pc_rd;
    logic              ibf_a, obf_n_a, intr_a, ibf_b, obf_n_b, intr_b;
    logic              a_stb_n, a_inte;

    assign sel     = sel_e'(addr);
    assign wr_fire = !cs_n && !wr_n && wr_q;
    assign rd_fall = !cs_n && !rd_n && rd_q;
    assign rd_done = rd_busy && rd_n;

    // bus strobe history
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b1;
            rd_q    <= 1'b1;
            rd_busy <= 1'b0;
            rd_sel  <= SEL_A;
        end else begin
            wr_q <= wr_n;
            rd_q <= rd_n;
            if (rd_fall) begin
                rd_busy <= 1'b1;
                rd_sel  <= sel;
            end else if (rd_n) begin
                rd_busy <= 1'b0;
            end
        end
    end

    pport_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_ctl   (wr_fire && sel == SEL_CTL),
        .wr_a     (wr_fire && sel == SEL_A),
        .wr_b     (wr_fire && sel == SEL_B),
        .wr_c     (wr_fire && sel == SEL_C),
        .wdata    (din),
        .hs_mask  (hs_mask),
        .ctl_word (ctl_word),
        .pa_lat   (pa_lat),
        .pb_lat   (pb_lat),
        .pc_lat   (pc_lat),
        .cfg_clr  (cfg_clr),
        .cfg      (cfg)
    );

    assign a_stb_n = cfg.a_in ? pc_in[PIN_A_STB]  : pc_in[PIN_A_ACK];
    assign a_inte  = cfg.a_in ? pc_lat[PIN_A_STB] : pc_lat[PIN_A_ACK];

    pport_hs_chan u_chan_a (
        .clk         (clk),
        .rst         (rst),
        .clr         (cfg_clr),
        .en          (cfg.a_hs),
        .is_in       (cfg.a_in),
        .stb_n       (a_stb_n),
        .inte        (a_inte),
        .cpu_wr      (wr_fire && sel == SEL_A),
        .cpu_rd_fall (rd_fall && sel == SEL_A),
        .cpu_rd_done (rd_done && rd_sel == SEL_A),
        .pdata       (pa_in),
        .ibf         (ibf_a),
        .obf_n       (obf_n_a),
        .intr        (intr_a),
        .held        (held_a)
    );

    pport_hs_chan u_chan_b (
        .clk         (clk),
        .rst         (rst),
        .clr         (cfg_clr),
        .en          (cfg.b_hs),
        .is_in       (cfg.b_in),
        .stb_n       (pc_in[PIN_B_STB]),
        .inte        (pc_lat[PIN_B_STB]),
        .cpu_wr      (wr_fire && sel == SEL_B),
        .cpu_rd_fall (rd_fall && sel == SEL_B),
        .cpu_rd_done (rd_done && rd_sel == SEL_B),
        .pdata       (pb_in),
        .ibf         (ibf_b),
        .obf_n       (obf_n_b),
        .intr        (intr_b),
        .held        (held_b)
    );

    // port C pin ownership
    always_comb begin
        hs_mask   = '0;
        stat_mask = '0;
        stb_mask  = '0;
        pc_stat   = '0;
        if (cfg.a_hs) begin
            hs_mask[PIN_A_INTR]   = 1'b1;
            stat_mask[PIN_A_INTR] = 1'b1;
            pc_stat[PIN_A_INTR]   = intr_a;
            if (cfg.a_in) begin
                hs_mask[PIN_A_STB]   = 1'b1;
                stb_mask[PIN_A_STB]  = 1'b1;
                hs_mask[PIN_A_IBF]   = 1'b1;
                stat_mask[PIN_A_IBF] = 1'b1;
                pc_stat[PIN_A_IBF]   = ibf_a;
            end else begin
                hs_mask[PIN_A_ACK]   = 1'b1;
                stb_mask[PIN_A_ACK]  = 1'b1;
                hs_mask[PIN_A_OBF]   = 1'b1;
                stat_mask[PIN_A_OBF] = 1'b1;
                pc_stat[PIN_A_OBF]   = obf_n_a;
            end
        end
        if (cfg.b_hs) begin
            hs_mask[PIN_B_INTR]   = 1'b1;
            hs_mask[PIN_B_STAT]   = 1'b1;
            hs_mask[PIN_B_STB]    = 1'b1;
            stb_mask[PIN_B_STB]   = 1'b1;
            stat_mask[PIN_B_INTR] = 1'b1;
            stat_mask[PIN_B_STAT] = 1'b1;
            pc_stat[PIN_B_INTR]   = intr_b;
            pc_stat[PIN_B_STAT]   = cfg.b_in ? ibf_b : obf_n_b;
        end
    end

    assign nib_out = {{NIB_W{~cfg.cu_in}}, {NIB_W{~cfg.cl_in}}};
    assign pc_oe   = (nib_out & ~hs_mask) | stat_mask;
    assign pc_out  = (pc_lat & ~hs_mask) | pc_stat;
    assign pc_rd   = (~hs_mask & ((pc_in & ~nib_out) | (pc_lat & nib_out)))
                   | pc_stat | (pc_lat & stb_mask);

    assign pa_oe  = {PORT_W{~cfg.a_in}};
    assign pa_out = pa_lat;
    assign pb_oe  = {PORT_W{~cfg.b_in}};
    assign pb_out = pb_lat;
    assign pa_rd  = cfg.a_in ? (cfg.a_hs ? held_a : pa_in) : pa_lat;
    assign pb_rd  = cfg.b_in ? (cfg.b_hs ? held_b : pb_in) : pb_lat;

    // read mux
    always_comb begin
        dout = '0;
        unique case (sel)
            SEL_A:   dout = pa_rd;
            SEL_B:   dout = pb_rd;
            SEL_C:   dout = pc_rd;
            SEL_CTL: dout = ctl_word;
            default: dout = '0;
        endcase
    end
    assign dout_en = !cs_n && !rd_n;
endmodule

// File: tb/sim_pport_ctl.sv
`timescale 1ns/1ps
module sim_pport_ctl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'b00;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_en;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    always #2 clk = ~clk;

    pport_ctl u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    // scoreboard
    string      tag_q[$];
    logic [7:0] exp_q[$];
    logic [7:0] obs_q[$];
    event       obs_ev;
    int         n_chk  = 0;
    int         n_fail = 0;
    bit         ended  = 1'b0;

    function automatic void sb_drain();
        while (obs_q.size() > 0) begin
            string      t;
            logic [7:0] e, o;
            t = tag_q.pop_front();
            e = exp_q.pop_front();
            o = obs_q.pop_front();
            n_chk++;
            if (o !== e) begin
                n_fail++;
                $display("FAIL %s actual=%02h expected=%02h", t, o, e);
            end
        end
    endfunction

    initial forever begin
        @(obs_ev);
        sb_drain();
    end

    task automatic chk(input string t, input logic [7:0] act, input logic [7:0] e);
        tag_q.push_back(t);
        exp_q.push_back(e);
        obs_q.push_back(act);
        -> obs_ev;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            sb_drain();
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; addr = a; din = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
        #1;
    endtask

    task automatic bus_rd(input logic [1:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        cs_n = 1'b0; addr = a; rd_n = 1'b0;
        #1;
        chk(t, dout, e);
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
        #1;
    endtask

    task automatic pin_step();
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 pa_oe", pa_oe, 8'h00);
        chk("R1 pb_oe", pb_oe, 8'h00);
        chk("R1 pc_oe", pc_oe, 8'h00);
        bus_rd(2'b11, 8'h9B, "R1 control after reset");

        // R2/R3/R5 all outputs, plain mode
        bus_wr(2'b11, 8'h80);
        bus_rd(2'b11, 8'h80, "R2 control readback");
        chk("R3 pa_oe all out", pa_oe, 8'hFF);
        chk("R3 pb_oe all out", pb_oe, 8'hFF);
        chk("R3 pc_oe all out", pc_oe, 8'hFF);
        bus_wr(2'b00, 8'h5A);
        bus_wr(2'b01, 8'hC3);
        bus_wr(2'b10, 8'h81);
        chk("R5 pa_out", pa_out, 8'h5A);
        chk("R5 pb_out", pb_out, 8'hC3);
        chk("R5 pc_out", pc_out, 8'h81);
        bus_rd(2'b00, 8'h5A, "R2 read port A");
        bus_rd(2'b01, 8'hC3, "R2 read port B");
        bus_rd(2'b10, 8'h81, "R2 read port C");

        // R4 single-bit commands
        bus_wr(2'b11, 8'h0B);
        chk("R4 set C5", pc_out, 8'hA1);
        bus_wr(2'b11, 8'h0E);
        chk("R4 clear C7", pc_out, 8'h21);
        bus_rd(2'b11, 8'h80, "R4 control unchanged");

        // R3/R5 mixed directions
        pc_in = 8'hA5;
        pb_in = 8'h3C;
        bus_wr(2'b11, 8'h8A);
        chk("R3 pa_oe mixed", pa_oe, 8'hFF);
        chk("R3 pb_oe mixed", pb_oe, 8'h00);
        chk("R3 pc_oe mixed", pc_oe, 8'h0F);
        chk("R3 latch cleared", pa_out, 8'h00);
        bus_rd(2'b01, 8'h3C, "R5 read B pins");
        bus_rd(2'b10, 8'hA0, "R5 read C mixed nibbles");

        // R11 unsupported group A mode
        pc_in = 8'hFF;
        bus_wr(2'b11, 8'hC0);
        chk("R11 pc_oe no handshake", pc_oe, 8'hFF);
        bus_wr(2'b00, 8'h77);
        bus_rd(2'b00, 8'h77, "R11 port A plain");

        // strobed input on both groups
        bus_wr(2'b11, 8'hB6);
        chk("R12 pc_oe strobed input", pc_oe, 8'hEB);
        chk("R6 idle status", pc_out, 8'h00);
        bus_wr(2'b11, 8'h09);
        bus_rd(2'b10, 8'h10, "R10 enable bit at C4");
        @(negedge clk);
        pa_in = 8'hC9; pc_in[4] = 1'b0;
        pin_step();
        chk("R6 IBF after strobe low", pc_out, 8'h20);
        pa_in = 8'h11;
        @(negedge clk);
        pc_in[4] = 1'b1;
        pin_step();
        chk("R7 INTR after strobe rise", pc_out, 8'h28);
        bus_rd(2'b00, 8'hC9, "R6 read captured byte");
        chk("R8 IBF and R7 INTR cleared by read", pc_out, 8'h00);

        @(negedge clk);
        pb_in = 8'h44; pc_in[2] = 1'b0;
        pin_step();
        chk("R6 IBF B", pc_out, 8'h02);
        @(negedge clk);
        pc_in[2] = 1'b1;
        pin_step();
        chk("R7 no INTR without enable", pc_out, 8'h02);
        @(negedge clk);
        pb_in = 8'h55; pc_in[2] = 1'b0;
        @(negedge clk);
        pc_in[2] = 1'b1;
        pin_step();
        bus_rd(2'b01, 8'h44, "R8 strobe ignored while full");
        chk("R8 IBF B cleared", pc_out, 8'h00);

        bus_wr(2'b10, 8'hFF);
        chk("R10 data write masked pins", pc_out, 8'hC0);
        bus_rd(2'b10, 8'hD0, "R10 enable kept after data write");

        // strobed output on both groups
        bus_wr(2'b11, 8'hA4);
        chk("R12 pc_oe strobed output", pc_oe, 8'hBB);
        chk("R9 OBF idle high", pc_out, 8'h82);
        bus_wr(2'b11, 8'h0D);
        bus_wr(2'b11, 8'h05);
        bus_wr(2'b00, 8'h3E);
        chk("R9 pa_out", pa_out, 8'h3E);
        chk("R9 OBF A low after write", pc_out, 8'h02);
        @(negedge clk);
        pc_in[6] = 1'b0;
        pin_step();
        chk("R9 ack A sets OBF and INTR", pc_out, 8'h8A);
        pc_in[6] = 1'b1;
        bus_wr(2'b00, 8'h3F);
        chk("R9 write clears INTR A", pc_out, 8'h02);
        @(negedge clk);
        pc_in[6] = 1'b0;
        pin_step();
        pc_in[6] = 1'b1;
        bus_wr(2'b01, 8'h99);
        chk("R9 pb_out", pb_out, 8'h99);
        chk("R9 OBF B low", pc_out, 8'h88);
        @(negedge clk);
        pc_in[2] = 1'b0;
        pin_step();
        chk("R9 ack B", pc_out, 8'h8B);
        pc_in[2] = 1'b1;
        bus_rd(2'b10, 8'hCF, "R10 status read in output mode");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule